// File: doc/BRIEF.md
# Instruction Packet Builder

This block collects retired instructions, one per clock, and assembles them into a wide packet that is written into a packet cache. As each instruction arrives it is given the next free slot. Each of its two source operands is checked against the instructions already in the packet. When an earlier slot of the same packet was the most recent writer of that register, the operand is rewritten from a register number into a reference to that slot. When a later slot overwrites a slot's destination, the earlier result cannot outlive the packet, so that slot is flagged dead.

All register comparison happens here, while instructions retire, and none of it is on the issue path. Issue logic that reads a finished packet sees slot references and dead flags. It never compares register numbers.

A packet is sealed and written in three cases: when it fills, when the caller requests a close, or when an incoming control transfer would exceed the per-packet transfer limit. In the last case the transfer opens the next packet.

Top module: `packet_builder`

## Requirements
- R1: While reset is asserted and afterwards until the first packet is sealed, `pkt_wr_en` is 0 and `pkt_len` and `pkt_data` are all zeros. In any cycle without a write these outputs are also zero.
- R2: Each operand is 6 bits. If no earlier slot of the current packet wrote the source register, the operand is {1'b0, reg[4:0]}. Otherwise bit 5 is 1, bits 4:3 are 0, and bits 2:0 hold the producing slot index.
- R3: When several earlier slots wrote the same register, an operand references the highest-numbered (most recent) of them.
- R4: A slot's dead flag is 1 exactly when a later slot of the same packet writes the same destination register. A slot with no destination, or whose destination is not rewritten later in the packet, has its dead flag at 0.
- R5: Accepting the 8th instruction seals the packet. `pkt_wr_en` is 1 with `pkt_len`=8 in the cycle after that clock edge. The producer table does not carry over, so sources in the next packet start with the plain register encoding.
- R6: An instruction accepted with `in_close`=1 is the last slot of its packet, and the packet is written in the next cycle. `in_close` with `in_valid`=0 writes the partial packet if it is non-empty and does nothing if it is empty.
- R7: A packet holds at most 2 control transfers. A third transfer seals the current packet without itself and becomes slot 0 of a new packet, with plain operands. An `in_close` on that same cycle is ignored.
- R8: Slot i occupies `pkt_data[i*28 +: 28]`. From the LSB up the fields are: opcode [7:0], operand A [13:8], operand B [19:14], destination [24:20] (zero when there is none), has-destination [25], transfer [26] and dead [27]. Slots at or above `pkt_len` are zero.
- R9: An instruction that reads and writes the same register takes its operand from the previous producer (or the plain register). It then becomes the new producer, and that previous producer becomes dead.
- R10: Cycles with `in_valid`=0 and `in_close`=0 leave the packet under construction unchanged and produce no write.
- R11: `pkt_wr_en` is high for exactly one cycle per sealed packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A retired instruction is presented this cycle |
| in_opcode | input | 8 | Opcode of the instruction |
| in_src_a | input | 5 | First source register |
| in_src_b | input | 5 | Second source register |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | 5 | Destination register |
| in_xfer | input | 1 | Instruction is a control transfer |
| in_close | input | 1 | Seal the packet after this cycle's instruction |
| pkt_wr_en | output | 1 | Packet cache write strobe |
| pkt_len | output | 4 | Number of occupied slots in the written packet |
| pkt_data | output | 224 | Eight packed slots of 28 bits |

## Verification
The bench goes after repeated writes to one register within a packet. A builder that kept the first producer instead of the latest would emit a stale slot index and mark the wrong slot dead. Self-referencing instructions are tested as well: updating the table before the lookup would make an instruction point at its own slot.

Packet boundaries are stressed from every direction, namely a full packet, a close with and without an instruction, a close on an empty builder, and a third transfer arriving with a close. A table that survived a seal would turn the next packet's sources into references to slots that do not exist. A builder that honoured the close on a split would write a second packet. A long stream over a tiny register subset, compared against an arithmetic model in the bench, exercises dense dependency chains in every slot position.

// File: rtl/pktb_pkg.sv
package pktb_pkg;

   // What the slot store does at the next clock edge.
   typedef enum logic [1:0] {
      EV_HOLD  = 2'd0,   // nothing accepted, nothing sealed
      EV_ADD   = 2'd1,   // append the incoming instruction
      EV_SEAL  = 2'd2,   // write out (including any incoming) and empty
      EV_SPLIT = 2'd3    // write out without incoming, incoming starts anew
   } pkt_event_e;

   function automatic int opnd_width(input int nreg);
      return $clog2(nreg) + 1;
   endfunction

   function automatic int slot_width(input int opw, input int nreg);
      return opw + 2 * opnd_width(nreg) + $clog2(nreg) + 3;
   endfunction

endpackage

// File: rtl/pktb_prod_table.sv
module pktb_prod_table #(
   parameter int NREG  = 32,
   parameter int NSLOT = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(NREG)-1:0]  rd_a_idx,
   input  logic [$clog2(NREG)-1:0]  rd_b_idx,
   input  logic [$clog2(NREG)-1:0]  rd_d_idx,
   output logic                     hit_a,
   output logic [$clog2(NSLOT)-1:0] slot_a,
   output logic                     hit_b,
   output logic [$clog2(NSLOT)-1:0] slot_b,
   output logic                     hit_d,
   output logic [$clog2(NSLOT)-1:0] slot_d,
   input  logic                     clr,
   input  logic                     wr_en,
   input  logic [$clog2(NREG)-1:0]  wr_idx,
   input  logic [$clog2(NSLOT)-1:0] wr_slot
);
   localparam int RW = $clog2(NREG);
   localparam int SW = $clog2(NSLOT);

   logic [NREG-1:0] vld_vec;
   logic [SW-1:0]   slot_arr [NREG];

   // One entry per architectural register: last producing slot + valid.
   // A write in the same cycle as a clear wins for its own entry.
   for (genvar r = 0; r < NREG; r++) begin : g_ent
      logic          v_q;
      logic [SW-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            s_q <= '0;
         end else if (wr_en && wr_idx == RW'(r)) begin
            v_q <= 1'b1;
            s_q <= wr_slot;
         end else if (clr) begin
            v_q <= 1'b0;
         end
      end
      assign vld_vec[r]  = v_q;
      assign slot_arr[r] = s_q;
   end

   assign hit_a  = vld_vec[rd_a_idx];
   assign slot_a = slot_arr[rd_a_idx];
   assign hit_b  = vld_vec[rd_b_idx];
   assign slot_b = slot_arr[rd_b_idx];
   assign hit_d  = vld_vec[rd_d_idx];
   assign slot_d = slot_arr[rd_d_idx];

endmodule

// File: rtl/pktb_opnd_enc.sv
module pktb_opnd_enc #(
   parameter int NREG  = 32,
   parameter int NSLOT = 8
) (
   input  logic [$clog2(NREG)-1:0]  reg_idx,
   input  logic                     hit,
   input  logic [$clog2(NSLOT)-1:0] slot,
   output logic [$clog2(NREG):0]    opnd
);
   localparam int RW = $clog2(NREG);
   localparam int SW = $clog2(NSLOT);

   // Top bit set selects a slot reference; clear selects a register.
   if (RW > SW) begin : g_pad
      assign opnd = hit ? {1'b1, {(RW - SW){1'b0}}, slot} : {1'b0, reg_idx};
   end else begin : g_nopad
      assign opnd = hit ? {1'b1, slot} : {1'b0, reg_idx};
   end

endmodule

// File: rtl/pktb_slot_store.sv
module pktb_slot_store
   import pktb_pkg::*;
#(
   parameter int NSLOT    = 8,
   parameter int SLOT_W   = 28,
   parameter int MAX_XFER = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  pkt_event_e                  ev,
   input  logic                        in_valid,
   input  logic [SLOT_W-1:0]           entry,
   input  logic                        kill_en,
   input  logic [$clog2(NSLOT)-1:0]    kill_idx,
   output logic [$clog2(NSLOT+1)-1:0]  count,
   output logic [$clog2(MAX_XFER+1)-1:0] xfer_cnt,
   output logic [NSLOT*SLOT_W-1:0]     seal_flat,
   output logic [$clog2(NSLOT+1)-1:0]  seal_len
);
   localparam int SW      = $clog2(NSLOT);
   localparam int CW      = $clog2(NSLOT+1);
   localparam int XW      = $clog2(MAX_XFER+1);
   localparam int DEAD_B  = SLOT_W - 1;
   localparam int XFER_B  = SLOT_W - 2;

   logic [SLOT_W-1:0] slot_q [NSLOT];
   logic [SLOT_W-1:0] merged [NSLOT];
   logic [CW-1:0]     count_q;
   logic [XW-1:0]     xfer_q;

   // View of the packet with the incoming instruction placed and the
   // overwritten producer flagged dead.
   for (genvar i = 0; i < NSLOT; i++) begin : g_merge
      always_comb begin
         merged[i] = slot_q[i];
         if (in_valid && count_q == CW'(i)) merged[i] = entry;
         if (kill_en && kill_idx == SW'(i)) merged[i][DEAD_B] = 1'b1;
      end
      assign seal_flat[i*SLOT_W +: SLOT_W] =
         (ev == EV_SPLIT || !in_valid) ? slot_q[i] : merged[i];
   end

   assign seal_len = (ev == EV_SPLIT) ? count_q : count_q + CW'(in_valid);
   assign count    = count_q;
   assign xfer_cnt = xfer_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
         count_q <= '0;
         xfer_q  <= '0;
      end else begin
         unique case (ev)
            EV_ADD: begin
               for (int i = 0; i < NSLOT; i++) slot_q[i] <= merged[i];
               count_q <= count_q + 1'b1;
               xfer_q  <= xfer_q + XW'(entry[XFER_B]);
            end
            EV_SEAL: begin
               for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
               count_q <= '0;
               xfer_q  <= '0;
            end
            EV_SPLIT: begin
               for (int i = 1; i < NSLOT; i++) slot_q[i] <= '0;
               slot_q[0] <= entry;
               count_q   <= CW'(1);
               xfer_q    <= XW'(entry[XFER_B]);
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/packet_builder.sv
module packet_builder
   import pktb_pkg::*;
#(
   parameter int NREG     = 32,
   parameter int NSLOT    = 8,
   parameter int OPW      = 8,
   parameter int MAX_XFER = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   input  logic [OPW-1:0]                        in_opcode,
   input  logic [$clog2(NREG)-1:0]               in_src_a,
   input  logic [$clog2(NREG)-1:0]               in_src_b,
   input  logic                                  in_has_dst,
   input  logic [$clog2(NREG)-1:0]               in_dst,
   input  logic                                  in_xfer,
   input  logic                                  in_close,
   output logic                                  pkt_wr_en,
   output logic [$clog2(NSLOT+1)-1:0]            pkt_len,
   output logic [NSLOT*slot_width(OPW,NREG)-1:0] pkt_data
);
   localparam int RW     = $clog2(NREG);
   localparam int SW     = $clog2(NSLOT);
   localparam int OW     = opnd_width(NREG);
   localparam int CW     = $clog2(NSLOT+1);
   localparam int XW     = $clog2(MAX_XFER+1);
   localparam int SLOT_W = slot_width(OPW, NREG);

   // Elaboration-time parameter checks.
   if (NSLOT < 2)          begin : g_chk_slots $error("NSLOT must be at least 2");          end
   if (SW > RW)            begin : g_chk_fit   $error("slot index must fit an operand");     end
   if (MAX_XFER < 1)       begin : g_chk_xfer  $error("MAX_XFER must be at least 1");        end
   if (OPW < 1)            begin : g_chk_opw   $error("OPW must be at least 1");             end
   if (NREG != (1 << RW))  begin : g_chk_nreg  $error("NREG must be a power of two");       end

   logic                 hit_a, hit_b, hit_d;
   logic [SW-1:0]        slot_a, slot_b, slot_d;
   logic [OW-1:0]        opnd_a, opnd_b;
   logic [CW-1:0]        count, seal_len;
   logic [XW-1:0]        xfer_cnt;
   logic [NSLOT*SLOT_W-1:0] seal_flat;
   logic [SLOT_W-1:0]    entry;
   logic                 overflow, seal_add, seal_flush;
   pkt_event_e           ev;

   // A transfer beyond the limit splits the packet; it sees an empty table.
   assign overflow   = in_valid && in_xfer && (xfer_cnt == XW'(MAX_XFER));
   assign seal_add   = in_valid && !overflow &&
                       (in_close || (count + 1'b1) == CW'(NSLOT));
   assign seal_flush = !in_valid && in_close && (count != '0);

   always_comb begin
      if (overflow)                     ev = EV_SPLIT;
      else if (seal_add || seal_flush)  ev = EV_SEAL;
      else if (in_valid)                ev = EV_ADD;
      else                              ev = EV_HOLD;
   end

   pktb_prod_table #(.NREG(NREG), .NSLOT(NSLOT)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (in_src_a),
      .rd_b_idx (in_src_b),
      .rd_d_idx (in_dst),
      .hit_a    (hit_a),
      .slot_a   (slot_a),
      .hit_b    (hit_b),
      .slot_b   (slot_b),
      .hit_d    (hit_d),
      .slot_d   (slot_d),
      .clr      (ev == EV_SEAL || ev == EV_SPLIT),
      .wr_en    (in_valid && in_has_dst && ev != EV_SEAL),
      .wr_idx   (in_dst),
      .wr_slot  (overflow ? '0 : count[SW-1:0])
   );

   pktb_opnd_enc #(.NREG(NREG), .NSLOT(NSLOT)) u_enc_a (
      .reg_idx (in_src_a),
      .hit     (hit_a && !overflow),
      .slot    (slot_a),
      .opnd    (opnd_a)
   );

   pktb_opnd_enc #(.NREG(NREG), .NSLOT(NSLOT)) u_enc_b (
      .reg_idx (in_src_b),
      .hit     (hit_b && !overflow),
      .slot    (slot_b),
      .opnd    (opnd_b)
   );

   // Slot layout from LSB: opcode, opnd A, opnd B, dst, has_dst, xfer, dead.
   assign entry = {1'b0, in_xfer, in_has_dst,
                   in_has_dst ? in_dst : {RW{1'b0}},
                   opnd_b, opnd_a, in_opcode};

   pktb_slot_store #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .MAX_XFER(MAX_XFER)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .in_valid  (in_valid),
      .entry     (entry),
      .kill_en   (in_valid && !overflow && in_has_dst && hit_d),
      .kill_idx  (slot_d),
      .count     (count),
      .xfer_cnt  (xfer_cnt),
      .seal_flat (seal_flat),
      .seal_len  (seal_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_wr_en <= 1'b0;
         pkt_len   <= '0;
         pkt_data  <= '0;
      end else if (ev == EV_SEAL || ev == EV_SPLIT) begin
         pkt_wr_en <= 1'b1;
         pkt_len   <= seal_len;
         pkt_data  <= seal_flat;
      end else begin
         pkt_wr_en <= 1'b0;
         pkt_len   <= '0;
         pkt_data  <= '0;
      end
   end

endmodule

// File: rtl/packet_builder_chk.sv
module packet_builder_chk
   import pktb_pkg::*;
#(
   parameter int NREG     = 32,
   parameter int NSLOT    = 8,
   parameter int OPW      = 8,
   parameter int MAX_XFER = 2
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  in_valid,
   input logic                                  in_close,
   input logic                                  pkt_wr_en,
   input logic [$clog2(NSLOT+1)-1:0]            pkt_len,
   input logic [NSLOT*slot_width(OPW,NREG)-1:0] pkt_data
);
   localparam int RW     = $clog2(NREG);
   localparam int OW     = opnd_width(NREG);
   localparam int SLOT_W = slot_width(OPW, NREG);

   logic [NSLOT-1:0] xbits;

   // R1: outputs are quiet whenever no packet is written
   assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_wr_en |-> (pkt_len == '0 && pkt_data == '0));

   // R8: a written packet holds between 1 and NSLOT slots
   assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_wr_en |-> (pkt_len != '0 && int'(pkt_len) <= NSLOT));

   // R7: transfer limit per packet
   assert_xfer_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_wr_en |-> ($countones(xbits) <= MAX_XFER));

   // R10: an idle cycle never produces a write on the next cycle
   assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !in_close) |=> !pkt_wr_en);

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic [SLOT_W-1:0] s;
      logic [OW-1:0]     oa, ob;
      logic              hd, dd;
      assign s        = pkt_data[i*SLOT_W +: SLOT_W];
      assign oa       = s[OPW +: OW];
      assign ob       = s[OPW+OW +: OW];
      assign hd       = s[OPW + 2*OW + RW];
      assign dd       = s[SLOT_W-1];
      assign xbits[i] = s[SLOT_W-2];

      // R2: slot references point strictly backwards
      assert_ref_back_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (pkt_wr_en && oa[OW-1]) |-> (int'(oa[RW-1:0]) < i));
      assert_ref_back_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (pkt_wr_en && ob[OW-1]) |-> (int'(ob[RW-1:0]) < i));

      // R4: dead only on a producer with a later slot after it
      assert_dead_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (pkt_wr_en && dd) |-> (hd && int'(pkt_len) > i + 1));

      // R8: unused slots are zero
      assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (pkt_wr_en && int'(pkt_len) <= i) |-> (s == '0));
   end

endmodule

bind packet_builder packet_builder_chk #(
   .NREG(NREG), .NSLOT(NSLOT), .OPW(OPW), .MAX_XFER(MAX_XFER)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_close  (in_close),
   .pkt_wr_en (pkt_wr_en),
   .pkt_len   (pkt_len),
   .pkt_data  (pkt_data)
);

// File: tb/packet_builder_tb.sv
`timescale 1ns/1ps
module packet_builder_tb;

   typedef logic [27:0] slot_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [7:0]   in_opcode = '0;
   logic [4:0]   in_src_a = '0, in_src_b = '0, in_dst = '0;
   logic         in_has_dst = 1'b0, in_xfer = 1'b0, in_close = 1'b0;
   logic         pkt_wr_en;
   logic [3:0]   pkt_len;
   logic [223:0] pkt_data;

   int n_checks = 0;
   int n_err    = 0;

   // bench model state
   slot_t        m_slot [8];
   int           m_cnt = 0, m_x = 0;
   bit           m_tv [32];
   int           m_ts [32];
   bit           e_emit;
   int           e_len;
   logic [223:0] e_data;
   logic [31:0]  lfsr = 32'h1ACE_B00C;

   always #10 clk = ~clk;   // 50 MHz

   packet_builder u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
      .in_src_a(in_src_a), .in_src_b(in_src_b), .in_has_dst(in_has_dst),
      .in_dst(in_dst), .in_xfer(in_xfer), .in_close(in_close),
      .pkt_wr_en(pkt_wr_en), .pkt_len(pkt_len), .pkt_data(pkt_data)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [223:0] act, input logic [223:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic slot_t get_slot(input logic [223:0] d, input int i);
      return d[i*28 +: 28];
   endfunction

   function automatic logic [5:0] enc(input int r);
      return m_tv[r] ? {3'b100, 3'(m_ts[r])} : {1'b0, 5'(r)};
   endfunction

   function automatic slot_t mk(input logic [7:0] op, input logic [5:0] ea,
                                input logic [5:0] eb, input bit hd,
                                input int d, input bit x);
      return {1'b0, x, hd, hd ? 5'(d) : 5'd0, eb, ea, op};
   endfunction

   task automatic m_seal();
      e_emit = 1'b1;
      e_len  = m_cnt;
      e_data = '0;
      for (int i = 0; i < 8; i++) begin
         e_data[i*28 +: 28] = m_slot[i];
         m_slot[i] = '0;
      end
      for (int r = 0; r < 32; r++) m_tv[r] = 1'b0;
      m_cnt = 0;
      m_x   = 0;
   endtask

   task automatic model(input bit v, input logic [7:0] op, input int sa,
                        input int sb, input bit hd, input int d,
                        input bit x, input bit cl);
      e_emit = 1'b0; e_len = 0; e_data = '0;
      if (v && x && m_x == 2) begin
         m_seal();
         m_slot[0] = mk(op, {1'b0, 5'(sa)}, {1'b0, 5'(sb)}, hd, d, x);
         m_cnt = 1; m_x = 1;
         if (hd) begin m_tv[d] = 1'b1; m_ts[d] = 0; end
      end else if (v) begin
         logic [5:0] ea, eb;
         ea = enc(sa); eb = enc(sb);
         if (hd && m_tv[d]) m_slot[m_ts[d]][27] = 1'b1;
         m_slot[m_cnt] = mk(op, ea, eb, hd, d, x);
         if (hd) begin m_tv[d] = 1'b1; m_ts[d] = m_cnt; end
         m_cnt++;
         if (x) m_x++;
         if (m_cnt == 8 || cl) m_seal();
      end else if (cl && m_cnt != 0) begin
         m_seal();
      end
   endtask

   // Drives one cycle (called just after a falling edge), checks the
   // registered outputs at the next falling edge.
   task automatic step(input bit v, input logic [7:0] op, input int sa,
                       input int sb, input bit hd, input int d,
                       input bit x, input bit cl, input string tag);
      in_valid = v; in_opcode = op; in_src_a = 5'(sa); in_src_b = 5'(sb);
      in_has_dst = hd; in_dst = 5'(d); in_xfer = x; in_close = cl;
      model(v, op, sa, sb, hd, d, x, cl);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_close = 1'b0;
      chk(pkt_wr_en == e_emit, tag, "wr_en", 224'(pkt_wr_en), 224'(e_emit));
      if (e_emit) begin
         chk(pkt_len == 4'(e_len), tag, "len", 224'(pkt_len), 224'(e_len));
         chk(pkt_data == e_data, tag, "data", pkt_data, e_data);
      end
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      return t ^ (t << 5);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      for (int r = 0; r < 32; r++) begin m_tv[r] = 1'b0; m_ts[r] = 0; end
      for (int i = 0; i < 8; i++) m_slot[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(pkt_wr_en == 1'b0 && pkt_len == '0 && pkt_data == '0, "R1",
          "reset outputs", {pkt_wr_en, pkt_len, 219'(0)} | pkt_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pkt_wr_en == 1'b0 && pkt_data == '0, "R1", "after reset", 224'(pkt_wr_en), '0);

      // R2 / R8: simple forward
      step(1, 8'h11, 1, 2, 1, 5, 0, 0, "R2");
      step(1, 8'h12, 5, 1, 0, 0, 0, 0, "R2");
      step(1, 8'h13, 5, 5, 1, 9, 0, 1, "R2");
      chk(get_slot(pkt_data, 1)[13:8] == 6'h20, "R2", "slot1 opA ref", 224'(get_slot(pkt_data, 1)[13:8]), 224'(6'h20));
      chk(get_slot(pkt_data, 1)[19:14] == 6'h01, "R2", "slot1 opB plain", 224'(get_slot(pkt_data, 1)[19:14]), 224'(6'h01));
      chk(get_slot(pkt_data, 0)[7:0] == 8'h11 && get_slot(pkt_data, 0)[24:20] == 5'd5, "R8",
          "slot0 fields", 224'(get_slot(pkt_data, 0)), 224'(mk(8'h11, 6'd1, 6'd2, 1, 5, 0)));

      // R3 / R4: latest producer wins, earlier one dead
      step(1, 8'h21, 0, 0, 1, 3, 0, 0, "R3");
      step(1, 8'h22, 0, 0, 1, 3, 0, 0, "R3");
      step(1, 8'h23, 3, 4, 0, 0, 0, 1, "R3");
      chk(get_slot(pkt_data, 2)[13:8] == 6'h21, "R3", "latest producer", 224'(get_slot(pkt_data, 2)[13:8]), 224'(6'h21));
      chk(get_slot(pkt_data, 0)[27] == 1'b1 && get_slot(pkt_data, 1)[27] == 1'b0, "R4",
          "dead flags", 224'({get_slot(pkt_data, 1)[27], get_slot(pkt_data, 0)[27]}), 224'(2'b01));

      // R9: read and write same register
      step(1, 8'h31, 0, 0, 1, 7, 0, 0, "R9");
      step(1, 8'h32, 7, 7, 1, 7, 0, 0, "R9");
      step(1, 8'h33, 7, 0, 0, 0, 0, 1, "R9");
      chk(get_slot(pkt_data, 1)[13:8] == 6'h20 && get_slot(pkt_data, 2)[13:8] == 6'h21, "R9",
          "self ref", 224'({get_slot(pkt_data, 2)[13:8], get_slot(pkt_data, 1)[13:8]}), 224'({6'h21, 6'h20}));

      // R5: full packet then table cleared
      for (int i = 0; i < 8; i++) step(1, 8'(8'h40 + i), i, 2, 1, 2, 0, 0, "R5");
      chk(pkt_len == 4'd8, "R5", "full len", 224'(pkt_len), 224'd8);
      step(1, 8'h50, 2, 2, 0, 0, 0, 1, "R5");
      chk(get_slot(pkt_data, 0)[13:8] == 6'h02, "R5", "no carry over", 224'(get_slot(pkt_data, 0)[13:8]), 224'(6'h02));

      // R6: close on empty, close flush of partial packet
      step(0, 0, 0, 0, 0, 0, 0, 1, "R6");
      step(1, 8'h61, 1, 1, 1, 1, 0, 0, "R6");
      step(1, 8'h62, 1, 1, 1, 1, 0, 0, "R6");
      // R10: bubbles leave the packet alone
      step(0, 8'hFF, 3, 3, 1, 1, 1, 0, "R10");
      step(0, 8'hFF, 4, 4, 1, 2, 0, 0, "R10");
      step(1, 8'h63, 1, 0, 0, 0, 0, 0, "R10");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R6");
      chk(pkt_len == 4'd3, "R6", "flush len", 224'(pkt_len), 224'd3);
      // R11: single-cycle strobe
      step(0, 0, 0, 0, 0, 0, 0, 0, "R11");

      // R7: third transfer splits, close ignored
      step(1, 8'h71, 0, 0, 1, 6, 1, 0, "R7");
      step(1, 8'h72, 6, 0, 0, 0, 1, 0, "R7");
      step(1, 8'h73, 6, 6, 1, 8, 1, 1, "R7");
      chk(pkt_len == 4'd2, "R7", "split len", 224'(pkt_len), 224'd2);
      step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
      step(1, 8'h74, 8, 6, 0, 0, 0, 1, "R7");
      chk(get_slot(pkt_data, 0)[19:0] == {6'h06, 6'h06, 8'h73} && get_slot(pkt_data, 1)[13:8] == 6'h20,
          "R7", "split slot0 plain", 224'(get_slot(pkt_data, 0)), 224'(mk(8'h73, 6'h06, 6'h06, 1, 8, 1)));

      // Sweep: dense dependencies over a small register subset (R2 R3 R4 R8)
      for (int n = 0; n < 4000; n++) begin
         bit v, hd, x, cl;
         int sa, sb, d;
         lfsr = nxt(lfsr);
         v  = lfsr[2:0] != 3'd0;
         hd = lfsr[3] | lfsr[4];
         x  = lfsr[6:5] == 2'd0;
         cl = lfsr[10:7] == 4'd0;
         sa = lfsr[11] ? int'(lfsr[13:12]) : int'(lfsr[18:14]);
         sb = int'(lfsr[20:19]);
         d  = lfsr[21] ? int'(lfsr[23:22]) : int'(lfsr[28:24]);
         step(v, lfsr[31:24], sa, sb, hd, d, x, cl, "R2 R3 R4 R8 sweep");
      end

      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule